// File: doc/BRIEF.md
# Segmented Byte-Lane Register File

This block holds the programmer-visible state of a 16-bit core with segmented addressing. It has four general data registers, four pointer/index registers that hold offsets inside a segment, four segment registers, an instruction pointer and a word of single-bit status and control flags. Operands are named by a 3-bit register code together with a width bit. In word mode the code selects a whole data register or a pointer register. In byte mode the code selects one byte half of a data register. Each byte half of a data register can be written without disturbing the other half.

Around the explicitly encoded operands, the block supplies the selections that instructions use implicitly. A multiply flag forces read port A onto the accumulator. A dedicated multiply-result port writes the accumulator and its paired data register in one cycle. An access-kind input picks the code, data or stack segment register for the segment output, and an override input can replace that choice. Effective-address arithmetic, the ALU and the bus interface sit outside this block.

Top module: `seg_regfile`

## Requirements
- R1: After a cycle with `rst` high, every register reads as zero. The outputs `rda_q`, `rdb_q`, `seg_sel_q`, `seg_q`, `ip_q` and `flags_q` are also zero.
- R2: In word mode (`*_wide`=1), codes 0–3 select data registers 0–3 and codes 4–7 select pointer registers 0–3. Both read ports are registered: the value for a code presented before a clock edge appears after that edge.
- R3: In byte mode (`*_wide`=0), codes 0–3 select bits 7:0 of data registers 0–3 and codes 4–7 select bits 15:8 of data registers 0–3. A byte read returns the byte in bits 7:0 with bits 15:8 zero. A byte write takes its value from `wr_data[7:0]`.
- R4: A byte write changes only the addressed half of one data register. A word write changes only the register it addresses.
- R5: A read that shares a clock edge with a write to the same register returns the value from before that write. The new value is visible from the next read.
- R6: While `mul_op` is high, read port A returns data register 0 as a word, whatever `rda_code` and `rda_wide` say. Port B is not affected.
- R7: `mul_wr_en` writes `mul_lo` into data register 0 and `mul_hi` into data register 2 on the same edge. On those two registers it takes priority over a general write in the same cycle. A general write to any other register in that cycle still takes effect.
- R8: Segment indices are 0 for code, 1 for data, 2 for stack and 3 for extra. With `seg_ovr_en` low, `acc_type` 0 (fetch) selects index 0, 1 (data) selects index 1, 2 (stack) selects index 2, and 3 also selects index 1. The output `seg_sel_q` carries the chosen index and `seg_q` carries that register's value, one edge after the inputs.
- R9: With `seg_ovr_en` high, `seg_ovr_idx` replaces the implicit segment choice for `seg_sel_q` and `seg_q`.
- R10: `seg_wr_en` writes `seg_wr_data` into the segment register at `seg_wr_idx`. A selection made on the same edge returns the old value.
- R11: `ip_wr_en` loads `ip_wr_data` into the instruction pointer, which appears on `ip_q` after the edge. Without a load, the pointer holds its value.
- R12: `flg_wr_en` updates only the flag bits whose `flg_wr_mask` bit is 1, taking each new value from `flg_wr_data`. All other flag bits keep their value, and without `flg_wr_en` no flag bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | General write enable |
| wr_code | input | CODE_W | Register code for the general write |
| wr_wide | input | 1 | 1 = word write, 0 = byte write |
| wr_data | input | DATA_W | General write data (byte writes use bits 7:0) |
| mul_wr_en | input | 1 | Multiply-result write enable |
| mul_lo | input | DATA_W | Low result word, written to data register 0 |
| mul_hi | input | DATA_W | High result word, written to data register 2 |
| rda_code | input | CODE_W | Read port A register code |
| rda_wide | input | 1 | Read port A width |
| mul_op | input | 1 | Forces read port A onto the accumulator |
| rdb_code | input | CODE_W | Read port B register code |
| rdb_wide | input | 1 | Read port B width |
| rda_q | output | DATA_W | Registered read port A data |
| rdb_q | output | DATA_W | Registered read port B data |
| seg_wr_en | input | 1 | Segment register write enable |
| seg_wr_idx | input | 2 | Segment register write index |
| seg_wr_data | input | DATA_W | Segment register write data |
| acc_type | input | 2 | Access kind: 0 fetch, 1 data, 2 stack, 3 data |
| seg_ovr_en | input | 1 | Segment override enable |
| seg_ovr_idx | input | 2 | Override segment index |
| seg_sel_q | output | 2 | Registered selected segment index |
| seg_q | output | DATA_W | Registered selected segment value |
| ip_wr_en | input | 1 | Instruction pointer load |
| ip_wr_data | input | DATA_W | Instruction pointer load value |
| ip_q | output | DATA_W | Instruction pointer |
| flg_wr_en | input | 1 | Flag write enable |
| flg_wr_mask | input | FLAG_W | Per-bit flag write mask |
| flg_wr_data | input | FLAG_W | New flag values |
| flags_q | output | FLAG_W | Status and control flags |

## Verification
The bench builds the block with its defaults: DATA_W=16, CODE_W=3 and FLAG_W=16. With only eight codes per width, it can read back every code in both widths after word fills and after byte writes of every code. It can also try every pairing of access kind, override enable and override index. An arithmetic model in the bench predicts each value, including the read-first collision and the case where the multiply port meets a general write.

// File: rtl/seg_regfile_pkg.sv
`timescale 1ns/1ps
package seg_regfile_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_DATA  = 2'd1,
    ACC_STACK = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  localparam logic [1:0] SEG_CODE  = 2'd0;
  localparam logic [1:0] SEG_DATA  = 2'd1;
  localparam logic [1:0] SEG_STACK = 2'd2;
  localparam logic [1:0] SEG_EXTRA = 2'd3;

  localparam int ACC_REG  = 0;
  localparam int PAIR_REG = 2;
endpackage

// File: rtl/srf_gpr.sv
`timescale 1ns/1ps
module srf_gpr #(
  parameter int W      = 16,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              wr_wide,
  input  logic [W-1:0]      wr_data,
  input  logic              mul_wr_en,
  input  logic [W-1:0]      mul_lo,
  input  logic [W-1:0]      mul_hi,
  input  logic [CODE_W-1:0] rda_code,
  input  logic              rda_wide,
  input  logic              rda_force_acc,
  input  logic [CODE_W-1:0] rdb_code,
  input  logic              rdb_wide,
  output logic [W-1:0]      rda_q,
  output logic [W-1:0]      rdb_q
);
  import seg_regfile_pkg::*;

  localparam int IW = CODE_W - 1;
  localparam int NG = 1 << IW;
  localparam int BW = W / 2;
  localparam logic [CODE_W-1:0] ACC_CODE = CODE_W'(ACC_REG);

  logic [NG-1:0][BW-1:0] lo_v;
  logic [NG-1:0][BW-1:0] hi_v;
  logic [NG-1:0][W-1:0]  ptr_v;

  logic [IW-1:0] wr_idx;
  assign wr_idx = wr_code[IW-1:0];

  for (genvar g = 0; g < NG; g++) begin : g_reg
    localparam logic [IW-1:0] GI = IW'(g);
    localparam bit MUL_TGT = (g == ACC_REG) || (g == PAIR_REG);
    logic [BW-1:0] lo_q, hi_q;
    logic [W-1:0]  ptr_q;
    logic          hit_word, hit_lo, hit_hi, hit_ptr, hit_mul;
    logic [W-1:0]  mul_val;

    assign hit_word = wr_en &&  wr_wide && !wr_code[IW] && (wr_idx == GI);
    assign hit_ptr  = wr_en &&  wr_wide &&  wr_code[IW] && (wr_idx == GI);
    assign hit_lo   = wr_en && !wr_wide && !wr_code[IW] && (wr_idx == GI);
    assign hit_hi   = wr_en && !wr_wide &&  wr_code[IW] && (wr_idx == GI);
    assign hit_mul  = mul_wr_en && MUL_TGT;
    assign mul_val  = (g == ACC_REG) ? mul_lo : mul_hi;

    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q <= '0;
        hi_q <= '0;
      end else if (hit_mul) begin
        lo_q <= mul_val[BW-1:0];
        hi_q <= mul_val[W-1:BW];
      end else begin
        if (hit_word || hit_lo) lo_q <= wr_data[BW-1:0];
        if (hit_word)           hi_q <= wr_data[W-1:BW];
        else if (hit_hi)        hi_q <= wr_data[BW-1:0];
      end
    end

    always_ff @(posedge clk) begin
      if (rst)          ptr_q <= '0;
      else if (hit_ptr) ptr_q <= wr_data;
    end

    assign lo_v[g]  = lo_q;
    assign hi_v[g]  = hi_q;
    assign ptr_v[g] = ptr_q;
  end

  function automatic logic [W-1:0] pick(
    input logic [CODE_W-1:0]    c,
    input logic                 wide,
    input logic [NG-1:0][BW-1:0] lo,
    input logic [NG-1:0][BW-1:0] hi,
    input logic [NG-1:0][W-1:0]  ptr
  );
    logic [IW-1:0] i;
    i = c[IW-1:0];
    if (wide) pick = c[IW] ? ptr[i] : {hi[i], lo[i]};
    else      pick = {{(W-BW){1'b0}}, (c[IW] ? hi[i] : lo[i])};
  endfunction

  logic [CODE_W-1:0] a_code;
  logic              a_wide;
  logic [W-1:0]      a_next, b_next;

  always_comb begin
    a_code = rda_force_acc ? ACC_CODE : rda_code;
    a_wide = rda_force_acc ? 1'b1     : rda_wide;
    a_next = pick(a_code, a_wide, lo_v, hi_v, ptr_v);
    b_next = pick(rdb_code, rdb_wide, lo_v, hi_v, ptr_v);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rda_q <= '0;
      rdb_q <= '0;
    end else begin
      rda_q <= a_next;
      rdb_q <= b_next;
    end
  end
endmodule

// File: rtl/srf_seg.sv
`timescale 1ns/1ps
module srf_seg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         seg_wr_en,
  input  logic [1:0]   seg_wr_idx,
  input  logic [W-1:0] seg_wr_data,
  input  logic [1:0]   acc_type,
  input  logic         seg_ovr_en,
  input  logic [1:0]   seg_ovr_idx,
  output logic [1:0]   seg_sel_q,
  output logic [W-1:0] seg_q
);
  import seg_regfile_pkg::*;

  localparam int NSEG = 4;

  logic [W-1:0] seg_mem [NSEG];
  logic [1:0]   implicit_sel, sel;
  acc_kind_e    kind;

  always_comb begin
    kind = acc_kind_e'(acc_type);
    unique case (kind)
      ACC_FETCH: implicit_sel = SEG_CODE;
      ACC_STACK: implicit_sel = SEG_STACK;
      default:   implicit_sel = SEG_DATA;
    endcase
    sel = seg_ovr_en ? seg_ovr_idx : implicit_sel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSEG; i++) seg_mem[i] <= '0;
    end else if (seg_wr_en) begin
      seg_mem[seg_wr_idx] <= seg_wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_sel_q <= '0;
      seg_q     <= '0;
    end else begin
      seg_sel_q <= sel;
      seg_q     <= seg_mem[sel];
    end
  end
endmodule

// File: rtl/srf_ctl.sv
`timescale 1ns/1ps
module srf_ctl #(
  parameter int W  = 16,
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ip_wr_en,
  input  logic [W-1:0]  ip_wr_data,
  input  logic          flg_wr_en,
  input  logic [FW-1:0] flg_wr_mask,
  input  logic [FW-1:0] flg_wr_data,
  output logic [W-1:0]  ip_q,
  output logic [FW-1:0] flags_q
);
  always_ff @(posedge clk) begin
    if (rst)           ip_q <= '0;
    else if (ip_wr_en) ip_q <= ip_wr_data;
  end

  for (genvar f = 0; f < FW; f++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                             flags_q[f] <= 1'b0;
      else if (flg_wr_en && flg_wr_mask[f]) flags_q[f] <= flg_wr_data[f];
    end
  end
endmodule

// File: rtl/seg_regfile.sv
`timescale 1ns/1ps
module seg_regfile #(
  parameter int DATA_W = 16,
  parameter int CODE_W = 3,
  parameter int FLAG_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              wr_wide,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              mul_wr_en,
  input  logic [DATA_W-1:0] mul_lo,
  input  logic [DATA_W-1:0] mul_hi,
  input  logic [CODE_W-1:0] rda_code,
  input  logic              rda_wide,
  input  logic              mul_op,
  input  logic [CODE_W-1:0] rdb_code,
  input  logic              rdb_wide,
  output logic [DATA_W-1:0] rda_q,
  output logic [DATA_W-1:0] rdb_q,
  input  logic              seg_wr_en,
  input  logic [1:0]        seg_wr_idx,
  input  logic [DATA_W-1:0] seg_wr_data,
  input  logic [1:0]        acc_type,
  input  logic              seg_ovr_en,
  input  logic [1:0]        seg_ovr_idx,
  output logic [1:0]        seg_sel_q,
  output logic [DATA_W-1:0] seg_q,
  input  logic              ip_wr_en,
  input  logic [DATA_W-1:0] ip_wr_data,
  output logic [DATA_W-1:0] ip_q,
  input  logic              flg_wr_en,
  input  logic [FLAG_W-1:0] flg_wr_mask,
  input  logic [FLAG_W-1:0] flg_wr_data,
  output logic [FLAG_W-1:0] flags_q
);
  srf_gpr #(.W(DATA_W), .CODE_W(CODE_W)) u_gpr (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_code(wr_code), .wr_wide(wr_wide), .wr_data(wr_data),
    .mul_wr_en(mul_wr_en), .mul_lo(mul_lo), .mul_hi(mul_hi),
    .rda_code(rda_code), .rda_wide(rda_wide), .rda_force_acc(mul_op),
    .rdb_code(rdb_code), .rdb_wide(rdb_wide),
    .rda_q(rda_q), .rdb_q(rdb_q)
  );

  srf_seg #(.W(DATA_W)) u_seg (
    .clk(clk), .rst(rst),
    .seg_wr_en(seg_wr_en), .seg_wr_idx(seg_wr_idx), .seg_wr_data(seg_wr_data),
    .acc_type(acc_type), .seg_ovr_en(seg_ovr_en), .seg_ovr_idx(seg_ovr_idx),
    .seg_sel_q(seg_sel_q), .seg_q(seg_q)
  );

  srf_ctl #(.W(DATA_W), .FW(FLAG_W)) u_ctl (
    .clk(clk), .rst(rst),
    .ip_wr_en(ip_wr_en), .ip_wr_data(ip_wr_data),
    .flg_wr_en(flg_wr_en), .flg_wr_mask(flg_wr_mask), .flg_wr_data(flg_wr_data),
    .ip_q(ip_q), .flags_q(flags_q)
  );
endmodule

// File: rtl/seg_regfile_chk.sv
`timescale 1ns/1ps
module seg_regfile_chk #(
  parameter int DATA_W = 16,
  parameter int FLAG_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              mul_wr_en,
  input logic [DATA_W-1:0] mul_lo,
  input logic              mul_op,
  input logic              wr_en,
  input logic [DATA_W-1:0] rda_q,
  input logic [1:0]        acc_type,
  input logic              seg_ovr_en,
  input logic [1:0]        seg_ovr_idx,
  input logic [1:0]        seg_sel_q,
  input logic              ip_wr_en,
  input logic [DATA_W-1:0] ip_wr_data,
  input logic [DATA_W-1:0] ip_q,
  input logic              flg_wr_en,
  input logic [FLAG_W-1:0] flg_wr_mask,
  input logic [FLAG_W-1:0] flags_q
);
  a_r7_mul_to_acc: assert property (@(posedge clk) disable iff (rst)
    (mul_wr_en ##1 mul_op) |=> (rda_q == $past(mul_lo, 2)));

  a_r8_fetch_code_seg: assert property (@(posedge clk) disable iff (rst)
    (!seg_ovr_en && acc_type == 2'd0) |=> (seg_sel_q == 2'd0));

  a_r8_stack_seg: assert property (@(posedge clk) disable iff (rst)
    (!seg_ovr_en && acc_type == 2'd2) |=> (seg_sel_q == 2'd2));

  a_r8_data_seg: assert property (@(posedge clk) disable iff (rst)
    (!seg_ovr_en && acc_type[0]) |=> (seg_sel_q == 2'd1));

  a_r9_override: assert property (@(posedge clk) disable iff (rst)
    seg_ovr_en |=> (seg_sel_q == $past(seg_ovr_idx)));

  a_r11_ip_load: assert property (@(posedge clk) disable iff (rst)
    ip_wr_en |=> (ip_q == $past(ip_wr_data)));

  a_r11_ip_hold: assert property (@(posedge clk) disable iff (rst)
    !ip_wr_en |=> $stable(ip_q));

  a_r12_masked_bits_kept: assert property (@(posedge clk) disable iff (rst)
    flg_wr_en |=> ((flags_q & ~$past(flg_wr_mask)) == ($past(flags_q) & ~$past(flg_wr_mask))));

  a_r12_no_write_hold: assert property (@(posedge clk) disable iff (rst)
    !flg_wr_en |=> $stable(flags_q));
endmodule

bind seg_regfile seg_regfile_chk #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_chk (
  .clk(clk), .rst(rst), .mul_wr_en(mul_wr_en), .mul_lo(mul_lo), .mul_op(mul_op),
  .wr_en(wr_en), .rda_q(rda_q), .acc_type(acc_type), .seg_ovr_en(seg_ovr_en),
  .seg_ovr_idx(seg_ovr_idx), .seg_sel_q(seg_sel_q), .ip_wr_en(ip_wr_en),
  .ip_wr_data(ip_wr_data), .ip_q(ip_q), .flg_wr_en(flg_wr_en),
  .flg_wr_mask(flg_wr_mask), .flags_q(flags_q)
);

// File: tb/seg_regfile_tb.sv
`timescale 1ns/1ps
module seg_regfile_tb;
  localparam int DW = 16;
  localparam int CW = 3;
  localparam int FW = 16;

  logic clk = 1'b0;
  logic rst;
  logic wr_en, wr_wide, mul_wr_en, rda_wide, mul_op, rdb_wide;
  logic [CW-1:0] wr_code, rda_code, rdb_code;
  logic [DW-1:0] wr_data, mul_lo, mul_hi, rda_q, rdb_q;
  logic seg_wr_en, seg_ovr_en, ip_wr_en, flg_wr_en;
  logic [1:0] seg_wr_idx, acc_type, seg_ovr_idx, seg_sel_q;
  logic [DW-1:0] seg_wr_data, seg_q, ip_wr_data, ip_q;
  logic [FW-1:0] flg_wr_mask, flg_wr_data, flags_q;

  always #5 clk = ~clk;

  seg_regfile #(.DATA_W(DW), .CODE_W(CW), .FLAG_W(FW)) u_dut (.*);

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [DW-1:0] m_d [4];
  logic [DW-1:0] m_p [4];
  logic [DW-1:0] m_s [4];
  logic [DW-1:0] m_ip;
  logic [FW-1:0] m_fl;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_rd(input int c, input bit wide);
    if (wide) return (c < 4) ? m_d[c] : m_p[c-4];
    return (c < 4) ? {8'h00, m_d[c][7:0]} : {8'h00, m_d[c-4][15:8]};
  endfunction

  function automatic logic [1:0] exp_sel(input int at, input bit ov, input int oi);
    if (ov) return 2'(oi);
    if (at == 0) return 2'd0;
    if (at == 2) return 2'd2;
    return 2'd1;
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    wr_en = 0; wr_wide = 1; wr_code = '0; wr_data = '0;
    mul_wr_en = 0; mul_lo = '0; mul_hi = '0; mul_op = 0;
    rda_code = '0; rda_wide = 1; rdb_code = '0; rdb_wide = 1;
    seg_wr_en = 0; seg_wr_idx = '0; seg_wr_data = '0;
    acc_type = '0; seg_ovr_en = 0; seg_ovr_idx = '0;
    ip_wr_en = 0; ip_wr_data = '0; flg_wr_en = 0; flg_wr_mask = '0; flg_wr_data = '0;
  endtask

  task automatic gwrite(input int c, input bit wide, input logic [DW-1:0] d);
    wr_en = 1; wr_code = CW'(c); wr_wide = wide; wr_data = d;
    tick();
    wr_en = 0;
    if (wide) begin
      if (c < 4) m_d[c] = d; else m_p[c-4] = d;
    end else begin
      if (c < 4) m_d[c][7:0] = d[7:0]; else m_d[c-4][15:8] = d[7:0];
    end
  endtask

  task automatic gread(input string req, input int c, input bit wide);
    rda_code = CW'(c); rda_wide = wide; rdb_code = CW'(c); rdb_wide = wide;
    tick();
    chk({req, " portA"}, 32'(rda_q), 32'(exp_rd(c, wide)));
    chk({req, " portB"}, 32'(rdb_q), 32'(exp_rd(c, wide)));
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle();
    for (int i = 0; i < 4; i++) begin m_d[i] = '0; m_p[i] = '0; m_s[i] = '0; end
    m_ip = '0; m_fl = '0;
    rst = 1;
    wr_en = 1; wr_data = 16'hFFFF; ip_wr_en = 1; ip_wr_data = 16'hFFFF;
    tick(); tick();
    idle();
    rst = 0;

    // R1: reset state
    chk("R1 rda", 32'(rda_q), 0); chk("R1 rdb", 32'(rdb_q), 0);
    chk("R1 sel", 32'(seg_sel_q), 0); chk("R1 seg", 32'(seg_q), 0);
    chk("R1 ip", 32'(ip_q), 0); chk("R1 flags", 32'(flags_q), 0);
    for (int c = 0; c < 8; c++) gread("R1 reg", c, 1);

    // R2/R3: word fills and full sweep in both widths
    for (int c = 0; c < 8; c++) gwrite(c, 1, 16'(((c + 1) * 16'h1357) ^ 16'hA5C3));
    for (int c = 0; c < 8; c++) gread("R2 word", c, 1);
    for (int c = 0; c < 8; c++) gread("R3 byte", c, 0);

    // R4: byte writes of every code keep the other half and pointers
    for (int c = 0; c < 8; c++) begin
      gwrite(c, 0, 16'hFF00 | 16'(8'h30 + c * 8'h11));
      gread("R4 after byte write", c % 4, 1);
    end
    for (int c = 0; c < 8; c++) gread("R4 all", c, 1);

    // R5: read-first on same-edge write
    wr_en = 1; wr_code = 3'd1; wr_wide = 1; wr_data = 16'hBEEF;
    rda_code = 3'd1; rda_wide = 1; rdb_code = 3'd1; rdb_wide = 1;
    tick(); wr_en = 0;
    chk("R5 old value", 32'(rda_q), 32'(m_d[1]));
    m_d[1] = 16'hBEEF;
    gread("R5 new value", 1, 1);

    // R6: mul_op forces port A onto accumulator
    mul_op = 1; rda_code = 3'd5; rda_wide = 0; rdb_code = 3'd5; rdb_wide = 1;
    tick(); mul_op = 0;
    chk("R6 portA acc", 32'(rda_q), 32'(m_d[0]));
    chk("R6 portB untouched", 32'(rdb_q), 32'(m_p[1]));

    // R7: multiply write with colliding and non-colliding general writes
    mul_wr_en = 1; mul_lo = 16'h1234; mul_hi = 16'h5678;
    wr_en = 1; wr_code = 3'd0; wr_wide = 1; wr_data = 16'hDEAD;
    tick();
    m_d[0] = 16'h1234; m_d[2] = 16'h5678;
    mul_lo = 16'h0F0F; mul_hi = 16'hF0F0;
    wr_code = 3'd3; wr_wide = 0; wr_data = 16'h00C4;
    tick();
    mul_wr_en = 0; wr_en = 0;
    m_d[0] = 16'h0F0F; m_d[2] = 16'hF0F0; m_d[3][7:0] = 8'hC4;
    for (int c = 0; c < 4; c++) gread("R7 mul write", c, 1);

    // R10: segment writes, read-first
    for (int s = 0; s < 4; s++) begin
      seg_wr_en = 1; seg_wr_idx = 2'(s); seg_wr_data = 16'(16'h2000 + s * 16'h0111);
      seg_ovr_en = 1; seg_ovr_idx = 2'(s);
      tick();
      chk("R10 read-first", 32'(seg_q), 32'(m_s[s]));
      m_s[s] = 16'(16'h2000 + s * 16'h0111);
    end
    seg_wr_en = 0;

    // R8/R9: every access kind x override x index
    for (int at = 0; at < 4; at++)
      for (int ov = 0; ov < 2; ov++)
        for (int oi = 0; oi < 4; oi++) begin
          acc_type = 2'(at); seg_ovr_en = ov[0]; seg_ovr_idx = 2'(oi);
          tick();
          chk(ov ? "R9 sel" : "R8 sel", 32'(seg_sel_q), 32'(exp_sel(at, ov[0], oi)));
          chk(ov ? "R9 val" : "R8 val", 32'(seg_q), 32'(m_s[exp_sel(at, ov[0], oi)]));
        end
    seg_ovr_en = 0;

    // R11: instruction pointer
    ip_wr_en = 1; ip_wr_data = 16'hC0DE; tick(); ip_wr_en = 0;
    chk("R11 load", 32'(ip_q), 32'h0000C0DE);
    tick(); tick();
    chk("R11 hold", 32'(ip_q), 32'h0000C0DE);

    // R12: masked flag updates
    for (int k = 0; k < 16; k++) begin
      logic [FW-1:0] mk, dv;
      mk = 16'((k * 16'h1F35) ^ 16'h8421);
      dv = 16'((k * 16'h6B29) + 16'h0F1E);
      flg_wr_en = 1; flg_wr_mask = mk; flg_wr_data = dv;
      tick();
      m_fl = (m_fl & ~mk) | (dv & mk);
      chk("R12 masked", 32'(flags_q), 32'(m_fl));
    end
    flg_wr_en = 0; flg_wr_mask = 16'hFFFF; flg_wr_data = ~m_fl;
    tick();
    chk("R12 disabled", 32'(flags_q), 32'(m_fl));

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule